// File: doc/BRIEF.md
# Serial Display Write Receiver

This block is the receive side of a write-only serial link into a display controller. An external host drives a serial clock, a serial data line, an active-low chip select and, in one of the two modes, a data/command select line. The block assembles bits into bytes and hands each byte to the core as a one-cycle write strobe. A flag with each strobe tells the core whether the byte goes to display memory or to the command decoder. Nothing can be read back over the link.

All four serial inputs pass through a synchronizer into the core clock domain. Serial clock edges are then found by comparing the synchronized clock with its value one cycle earlier, so the whole block runs on the core clock. The serial clock must therefore be slower than the core clock. Each half period must last at least `SYNC_STAGES` + 1 core cycles.

A static mode input picks between two ways of telling data from commands. In 4-wire mode the select line decides this. In 3-wire mode the select line is ignored. A two-byte length command arms a counter, and that counter marks how many of the following bytes are data. No framing marker exists in either mode. After a bit slip, only the synchronous reset brings back byte alignment.

Top module: `dsp_serial_rx`

## Requirements
- R1: Serial data is sampled on each rising serial clock edge while `cs_n` is low, most significant bit first. The eighth sampled bit completes a byte, which appears on `wr_data` with bit 7 holding the first bit received.
- R2: Every completed byte gives exactly one `wr_valid` pulse, one core cycle wide. The pulse comes no more than 4 core cycles after the serial clock rise that completed the byte.
- R3: In 4-wire mode (`mode_3wire` = 0), `wr_is_data` equals the value of `dc_sel` at the byte's eighth rising edge. A value of 1 means display data and 0 means command.
- R4: Bytes follow each other with no extra clocks and no terminator. Every group of eight rising edges forms one complete byte.
- R5: While `cs_n` is high, serial clock edges shift nothing and the bit position is held. Bits sent before and after such a gap join into a single byte.
- R6: In 3-wire mode (`mode_3wire` = 1), `dc_sel` has no effect. When no length window is open, every byte is reported as a command (`wr_is_data` = 0).
- R7: In 3-wire mode, the command byte 0xB6 followed by a parameter byte P opens a window of P+1 data bytes. P = 0x00 gives 1 byte and P = 0xFF gives 256. Both the opcode byte and P are reported as commands. The next P+1 bytes are reported as data, and the byte after the window is reported as a command.
- R8: A low `rst_n` at a core clock edge clears the bit position, the shift register and the length window, and holds `wr_valid` low.
- R9: In 4-wire mode, the byte 0xB6 opens no length window. Every byte's flag follows `dc_sel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset; also the only way to restore framing |
| mode_3wire | input | 1 | Static mode: 0 = 4-wire (select line used), 1 = 3-wire (length window) |
| sck | input | 1 | Serial clock from the host, asynchronous to `clk` |
| sda | input | 1 | Serial data, MSB first |
| cs_n | input | 1 | Active-low chip select |
| dc_sel | input | 1 | Data/command select (1 = data); used in 4-wire mode only |
| wr_valid | output | 1 | One-cycle strobe for a received byte |
| wr_data | output | 8 | Received byte |
| wr_is_data | output | 1 | 1 = display data byte, 0 = command byte |

## Verification
A wrong bit position inside the block shows on the very next strobe. Either the byte comes out rotated, or the strobe arrives after too few or too many serial clocks. The bench therefore checks exact byte values across chip-select gaps and across resets taken in the middle of a byte. A length counter off by one, or a window that stays open, changes only the flag. That error shows at the last byte of the window or at the byte just after it. This is why windows are checked at their edges, including the 1-byte and 256-byte extremes. A synchronizer or edge-detect fault shows as an extra or missing strobe within a few core cycles. The bench therefore measures strobe width and delay directly.

// File: rtl/dsp_srx_pkg.sv
// Shared constants for the serial display write receiver.
// Assumes byte-wide transfers; the length opcode is a single fixed code.
package dsp_srx_pkg;
    localparam int BYTE_W = 8;
    localparam logic [BYTE_W-1:0] LEN_OPCODE = 8'hB6;
    typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/dsp_srx_sync.sv
// Multi-stage synchronizer for a vector of asynchronous inputs.
// Each bit gets its own flop chain; reset loads RST_VAL so idle inputs
// look idle straight after reset. Assumes inputs change slowly relative to clk.
module dsp_srx_sync #(
    parameter int             WIDTH   = 4,
    parameter int             STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [STAGES-1:0] chain [WIDTH];

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        // Shift one input bit through its flop chain.
        always_ff @(posedge clk) begin
            if (!rst_n) chain[i] <= {STAGES{RST_VAL[i]}};
            else        chain[i] <= {chain[i][STAGES-2:0], din[i]};
        end
        assign dout[i] = chain[i][STAGES-1];
    end
endmodule

// File: rtl/dsp_srx_shifter.sv
// Bit assembler: detects rising serial clock edges on the synchronized
// clock while select is low, shifts data in MSB first and flags the eighth bit.
// Assumes each serial clock half period spans more than one core cycle.
module dsp_srx_shifter #(
    parameter int BITS = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sck_s,
    input  logic            sda_s,
    input  logic            csn_s,
    output logic            byte_done,
    output logic [BITS-1:0] byte_val
);
    localparam int CNT_W = $clog2(BITS);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(BITS - 1);

    logic             sck_prev;
    logic [CNT_W-1:0] bit_cnt;
    logic [BITS-1:0]  shreg;
    logic             rise;

    // Qualified rising edge and the byte completed by it.
    always_comb begin
        rise      = sck_s & ~sck_prev & ~csn_s;
        byte_done = rise && (bit_cnt == LAST);
        byte_val  = {shreg[BITS-2:0], sda_s};
    end

    // Edge history, shift register and bit position.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_prev <= 1'b0;
            bit_cnt  <= '0;
            shreg    <= '0;
        end else begin
            sck_prev <= sck_s;
            if (rise) begin
                shreg   <= {shreg[BITS-2:0], sda_s};
                bit_cnt <= (bit_cnt == LAST) ? '0 : bit_cnt + 1'b1;
            end
        end
    end

    assert_cnt_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        csn_s |=> $stable(bit_cnt));

    assert_byte_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        byte_done |=> (bit_cnt == '0));

    assert_reset_clear_R8: assert property (@(posedge clk)
        !rst_n |=> (bit_cnt == '0 && shreg == '0));
endmodule

// File: rtl/dsp_srx_len_ctl.sv
// Data/command classifier. In 4-wire mode it passes the select line through.
// In 3-wire mode it watches for the length opcode and its parameter and then
// marks the announced number of following bytes as data. Mode is static.
module dsp_srx_len_ctl
    import dsp_srx_pkg::*;
#(
    parameter int            BITS = 8,
    parameter logic [BITS-1:0] OPC = LEN_OPCODE
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            mode_3w,
    input  logic            byte_done,
    input  logic [BITS-1:0] byte_val,
    input  logic            dc_s,
    output logic            is_data,
    output logic [BITS:0]   rem_cnt
);
    logic wait_param;

    // Flag for the byte completing in this cycle.
    always_comb begin
        if (!mode_3w) is_data = dc_s;
        else          is_data = (rem_cnt != '0);
    end

    // Window counter and opcode tracking, 3-wire mode only.
    always_ff @(posedge clk) begin
        if (!rst_n || !mode_3w) begin
            rem_cnt    <= '0;
            wait_param <= 1'b0;
        end else if (byte_done) begin
            if (rem_cnt != '0) begin
                rem_cnt <= rem_cnt - 1'b1;
            end else if (wait_param) begin
                rem_cnt    <= {1'b0, byte_val} + 1'b1;
                wait_param <= 1'b0;
            end else if (byte_val == OPC) begin
                wait_param <= 1'b1;
            end
        end
    end

    assert_window_dec_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_done && rem_cnt != '0) |=> (rem_cnt == $past(rem_cnt) - 1'b1));
endmodule

// File: rtl/dsp_serial_rx.sv
// Top of the serial display write receiver. Synchronizes the serial pins,
// assembles bytes, classifies them and registers a one-cycle write strobe.
// Assumes mode_3wire changes only while rst_n is low.
module dsp_serial_rx
    import dsp_srx_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_3wire,
    input  logic              sck,
    input  logic              sda,
    input  logic              cs_n,
    input  logic              dc_sel,
    output logic              wr_valid,
    output logic [BYTE_W-1:0] wr_data,
    output logic              wr_is_data
);
    logic [3:0]  pins_s;
    logic        sck_s, sda_s, csn_s, dc_s;
    logic        byte_done, cls_data;
    byte_t       byte_val;
    logic [BYTE_W:0] rem_cnt;

    dsp_srx_sync #(.WIDTH(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b0010)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .din({sck, sda, cs_n, dc_sel}), .dout(pins_s));

    assign {sck_s, sda_s, csn_s, dc_s} = pins_s;

    dsp_srx_shifter #(.BITS(BYTE_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .sck_s(sck_s), .sda_s(sda_s), .csn_s(csn_s),
        .byte_done(byte_done), .byte_val(byte_val));

    dsp_srx_len_ctl #(.BITS(BYTE_W), .OPC(LEN_OPCODE)) u_len (
        .clk(clk), .rst_n(rst_n), .mode_3w(mode_3wire), .byte_done(byte_done),
        .byte_val(byte_val), .dc_s(dc_s), .is_data(cls_data), .rem_cnt(rem_cnt));

    // Registered write strobe toward display memory or command decoder.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_valid   <= 1'b0;
            wr_data    <= '0;
            wr_is_data <= 1'b0;
        end else begin
            wr_valid <= byte_done;
            if (byte_done) begin
                wr_data    <= byte_val;
                wr_is_data <= cls_data;
            end
        end
    end

    assert_single_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |=> !wr_valid);

    assert_dc_follow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_3wire && wr_valid) |-> (wr_is_data == $past(dc_s)));

    assert_idle_cmd_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_3wire && byte_done && rem_cnt == '0) |=> (wr_valid && !wr_is_data));
endmodule

// File: tb/dsp_serial_rx_tb.sv
// Directed bench: one task per scenario, each checking its own strobes.
module dsp_serial_rx_tb_top;
    localparam int HALF = 4;  // core cycles per serial half period

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_3wire = 1'b0;
    logic       sck = 1'b0, sda = 1'b0, cs_n = 1'b1, dc_sel = 1'b0;
    logic       wr_valid;
    logic [7:0] wr_data;
    logic       wr_is_data;

    int n_chk = 0, n_bad = 0, got = 0;
    logic [8:0] rec [0:1023];
    bit done_flag = 1'b0;

    always #10 clk = ~clk;

    dsp_serial_rx dut_i (
        .clk(clk), .rst_n(rst_n), .mode_3wire(mode_3wire), .sck(sck), .sda(sda),
        .cs_n(cs_n), .dc_sel(dc_sel), .wr_valid(wr_valid), .wr_data(wr_data),
        .wr_is_data(wr_is_data));

    // Record each strobe away from the active edge.
    always @(negedge clk) begin
        if (rst_n && wr_valid && got < 1024) begin
            rec[got] = {wr_is_data, wr_data};
            got = got + 1;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset(input bit m3);
        @(negedge clk);
        rst_n = 1'b0; sck = 1'b0; cs_n = 1'b1; mode_3wire = m3;
        wait_n(4);
        rst_n = 1'b1;
        wait_n(4);
        got = 0;
    endtask

    task automatic send_bit(input bit b);
        sck = 1'b0; sda = b;
        wait_n(HALF);
        sck = 1'b1;
        wait_n(HALF);
    endtask

    task automatic send_byte(input logic [7:0] v, input bit dc);
        dc_sel = dc;
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
        sck = 1'b0;
    endtask

    task automatic expect_rec(input int idx, input logic [7:0] v, input bit f, input string tag);
        chk(got > idx, {tag, " strobe count"}, got, idx + 1);
        if (got > idx) begin
            chk(rec[idx][7:0] == v, {tag, " data"}, rec[idx][7:0], v);
            chk(rec[idx][8] == f, {tag, " flag"}, rec[idx][8], f);
        end
    endtask

    task automatic t_reset_state;
        do_reset(1'b0);
        chk(wr_valid == 1'b0, "R8 valid low after reset", wr_valid, 0);
        chk(got == 0, "R8 no strobe after reset", got, 0);
    endtask

    task automatic t_4w_basic;
        do_reset(1'b0);
        cs_n = 1'b0; wait_n(4);
        send_byte(8'hA5, 1'b1);
        send_byte(8'h3C, 1'b0);
        wait_n(8);
        expect_rec(0, 8'hA5, 1'b1, "R1 R3 data byte");
        expect_rec(1, 8'h3C, 1'b0, "R1 R3 command byte");
        chk(got == 2, "R2 one strobe per byte", got, 2);
    endtask

    task automatic t_latency;
        int lat;
        do_reset(1'b0);
        cs_n = 1'b0; wait_n(4);
        dc_sel = 1'b1;
        for (int i = 6; i >= 0; i--) send_bit(1'b1);
        sck = 1'b0; sda = 1'b0; wait_n(HALF);
        sck = 1'b1;
        lat = 0;
        while (!wr_valid && lat < 10) begin
            @(negedge clk);
            lat++;
        end
        chk(lat >= 1 && lat <= 4, "R2 strobe delay", lat, 3);
        @(negedge clk);
        chk(wr_valid == 1'b0, "R2 strobe one cycle wide", wr_valid, 0);
        sck = 1'b0; wait_n(8);
        expect_rec(0, 8'hFE, 1'b1, "R1 latency byte");
    endtask

    task automatic t_back_to_back;
        do_reset(1'b0);
        cs_n = 1'b0; wait_n(4);
        send_byte(8'h81, 1'b0);
        send_byte(8'h7E, 1'b1);
        send_byte(8'h00, 1'b1);
        wait_n(8);
        chk(got == 3, "R4 byte count", got, 3);
        expect_rec(0, 8'h81, 1'b0, "R4 first");
        expect_rec(1, 8'h7E, 1'b1, "R4 second");
        expect_rec(2, 8'h00, 1'b1, "R4 third");
    endtask

    task automatic t_cs_gap;
        do_reset(1'b0);
        cs_n = 1'b0; wait_n(4);
        dc_sel = 1'b1;
        send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b1);
        sck = 1'b0; wait_n(4);
        cs_n = 1'b1; wait_n(4);
        for (int i = 0; i < 5; i++) send_bit(1'b0);
        sck = 1'b0; wait_n(4);
        chk(got == 0, "R5 no strobe while deselected", got, 0);
        cs_n = 1'b0; wait_n(4);
        send_bit(1'b0); send_bit(1'b1); send_bit(1'b1); send_bit(1'b0);
        sck = 1'b0; wait_n(8);
        chk(got == 1, "R5 single joined byte", got, 1);
        expect_rec(0, 8'hB6, 1'b1, "R5 joined value");
    endtask

    task automatic t_4w_opcode;
        do_reset(1'b0);
        cs_n = 1'b0; wait_n(4);
        send_byte(8'hB6, 1'b0);
        send_byte(8'h02, 1'b0);
        send_byte(8'h11, 1'b0);
        send_byte(8'h22, 1'b1);
        wait_n(8);
        expect_rec(2, 8'h11, 1'b0, "R9 no window");
        expect_rec(3, 8'h22, 1'b1, "R9 flag follows dc_sel");
    endtask

    task automatic t_3w_window;
        do_reset(1'b1);
        cs_n = 1'b0; wait_n(4);
        send_byte(8'h40, 1'b1);
        send_byte(8'hB6, 1'b1);
        send_byte(8'h02, 1'b1);
        send_byte(8'hD1, 1'b0);
        send_byte(8'hD2, 1'b0);
        send_byte(8'hD3, 1'b0);
        send_byte(8'h55, 1'b1);
        send_byte(8'hB6, 1'b0);
        send_byte(8'h00, 1'b0);
        send_byte(8'hE1, 1'b0);
        send_byte(8'hB6, 1'b1);
        wait_n(8);
        expect_rec(0, 8'h40, 1'b0, "R6 dc_sel ignored");
        expect_rec(1, 8'hB6, 1'b0, "R7 opcode is command");
        expect_rec(2, 8'h02, 1'b0, "R7 parameter is command");
        expect_rec(3, 8'hD1, 1'b1, "R7 window first");
        expect_rec(5, 8'hD3, 1'b1, "R7 window last");
        expect_rec(6, 8'h55, 1'b0, "R7 after window");
        expect_rec(9, 8'hE1, 1'b1, "R7 P=0 one byte");
        expect_rec(10, 8'hB6, 1'b0, "R7 P=0 closes");
    endtask

    task automatic t_3w_max;
        int ndata;
        do_reset(1'b1);
        cs_n = 1'b0; wait_n(4);
        send_byte(8'hB6, 1'b0);
        send_byte(8'hFF, 1'b0);
        for (int i = 0; i < 256; i++) send_byte(8'(i), 1'b0);
        send_byte(8'h99, 1'b1);
        wait_n(8);
        chk(got == 259, "R7 max strobe count", got, 259);
        ndata = 0;
        for (int i = 2; i < 258; i++) if (rec[i][8]) ndata++;
        chk(ndata == 256, "R7 max window data count", ndata, 256);
        expect_rec(257, 8'hFF, 1'b1, "R7 max window last");
        expect_rec(258, 8'h99, 1'b0, "R7 max after window");
    endtask

    task automatic t_reset_mid;
        do_reset(1'b1);
        cs_n = 1'b0; wait_n(4);
        send_byte(8'hB6, 1'b0);
        send_byte(8'h05, 1'b0);
        send_byte(8'h77, 1'b0);
        send_bit(1'b1); send_bit(1'b1); send_bit(1'b1);
        sck = 1'b0; wait_n(4);
        @(negedge clk); rst_n = 1'b0; wait_n(3); rst_n = 1'b1; wait_n(4);
        got = 0;
        send_byte(8'h5A, 1'b1);
        wait_n(8);
        chk(got == 1, "R8 realigned count", got, 1);
        expect_rec(0, 8'h5A, 1'b0, "R8 bits and window cleared");
    endtask

    initial begin
        t_reset_state();
        t_4w_basic();
        t_latency();
        t_back_to_back();
        t_cs_gap();
        t_4w_opcode();
        t_3w_window();
        t_3w_max();
        t_reset_mid();
        if (!done_flag) begin
            done_flag = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done_flag) begin
            done_flag = 1'b1;
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule